// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table held in memory. It is given a virtual page number, a flag saying whether the access that missed is a write, and the byte address of the first-level table. It then performs the dependent reads one at a time over a plain request/response memory port. It reports either the physical frame number with its write permission, or a fault with a code that tells the caller why the walk stopped.

Virtual addresses are 32 bits with 4 KB pages. The 20-bit page number splits into two 10-bit indices. Each table holds 1024 entries of 32 bits, so one table fills exactly one page. A directory entry that is not valid ends the walk after a single read. Filling a translation cache, coordinating with other cores and handling faults in software are left to the surrounding system.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done_valid` and `mem_req_valid` are 0.
- R2: The first read goes to `root_base + vpn[19:10] * 4`. The upper ten page-number bits are the directory index, including the extreme indices 0 and 1023.
- R3: The second read goes to `{dir_entry[31:12], 12'h000} + vpn[9:0] * 4`. The lower ten page-number bits index the leaf table.
- R4: Entry format for both levels: bit 0 = present, bit 1 = write allowed, bits 31:12 = frame (or next-table page); the other bits are ignored.
- R5: A walk whose two entries are both present ends with `done_valid` high for exactly one cycle. In that cycle `done_fault` is 0, `fault_code` is 2'b00, `done_frame` is the leaf frame, and `done_writable` is the AND of the two write bits. The walker is idle again in the following cycle.
- R6: A directory entry with bit 0 clear ends the walk with `done_fault` set and `fault_code` 2'b01, after exactly one memory read.
- R7: A leaf entry with bit 0 clear ends the walk with `done_fault` set and `fault_code` 2'b10, after exactly two reads.
- R8: When `req_write` is 1 and either level's write bit is 0, the walk ends with `done_fault` set and `fault_code` 2'b11, after two reads. A read through the same entries succeeds with `done_writable` 0.
- R9: Each read is a single-cycle `mem_req_valid` pulse. No further read is issued until `mem_rsp_valid` returns, whatever the response latency.
- R10: A request is taken only while `req_ready` is 1, which is only when the walker is idle. A `req_valid` pulse during a walk changes neither the read sequence nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request strobe |
| req_vpn | input | 20 | Virtual page number to resolve |
| req_write | input | 1 | Access that missed is a write |
| root_base | input | 32 | Byte address of the first-level table |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read |
| done_valid | output | 1 | Walk finished (one cycle) |
| done_fault | output | 1 | Walk finished with a fault |
| fault_code | output | 2 | 00 none, 01 directory absent, 10 leaf absent, 11 write not allowed |
| done_frame | output | 20 | Resolved frame number |
| done_writable | output | 1 | Resolved page may be written |

## Verification
The walk is driven with a set of page numbers: one in mid-range, and others at index 0 and index 1023 at both levels. This separates a correct index split and entry scaling from shifted or swapped fields. Table contents are chosen so that each walk stops at a different point: an absent directory entry, an absent leaf, and a write denied by the directory or by the leaf. Each stop is checked by its fault code and by the number of reads issued, which shows whether the walker stopped early. Walks run with response latencies of one and three cycles, and one walk receives an extra request pulse midway. These runs show whether the walker holds its read request, or takes new work, before the outstanding read is answered.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        WALK_IDLE  = 3'd0,
        WALK_DIR   = 3'd1,
        WALK_LEAF  = 3'd2,
        WALK_OK    = 3'd3,
        WALK_ERR   = 3'd4
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_DIR  = 2'b01,
        FLT_LEAF = 2'b10,
        FLT_PROT = 2'b11
    } fault_e;

    localparam int unsigned PTE_PRESENT_BIT = 0;
    localparam int unsigned PTE_WRITE_BIT   = 1;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W        = 32,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4,
    localparam int SHIFT      = $clog2(ENTRY_BYTES)
) (
    input  logic [PA_W-1:0]  table_base,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  entry_addr
);
    logic [PA_W-1:0] offset;

    always_comb begin
        offset     = PA_W'(index) << SHIFT;
        entry_addr = table_base + offset;
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import pt_walker_pkg::*;
#(
    parameter int ENTRY_W    = 32,
    parameter int PAGE_OFF_W = 12,
    parameter int FRAME_W    = 20
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               present,
    output logic               writable,
    output logic [FRAME_W-1:0] frame
);
    always_comb begin
        present  = entry[PTE_PRESENT_BIT];
        writable = entry[PTE_WRITE_BIT];
        frame    = entry[PAGE_OFF_W +: FRAME_W];
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int PAGE_OFF_W  = 12,
    parameter int LVL1_W      = 10,
    parameter int ENTRY_W     = 32,
    localparam int VPN_W      = VA_W - PAGE_OFF_W,
    localparam int LVL2_W     = VPN_W - LVL1_W,
    localparam int FRAME_W    = PA_W - PAGE_OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic               req_write,
    input  logic [PA_W-1:0]    root_base,
    output logic               req_ready,
    output logic               mem_req_valid,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               done_valid,
    output logic               done_fault,
    output logic [1:0]         fault_code,
    output logic [FRAME_W-1:0] done_frame,
    output logic               done_writable
);
    localparam int IDX_W       = (LVL1_W > LVL2_W) ? LVL1_W : LVL2_W;
    localparam int ENTRY_BYTES = ENTRY_W / 8;

    typedef struct packed {
        walk_state_e        state;
        logic               issued;
        logic [VPN_W-1:0]   vpn;
        logic               write;
        logic [PA_W-1:0]    base;
        logic               dir_wr;
        fault_e             code;
        logic [FRAME_W-1:0] frame;
        logic               wr_ok;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic [IDX_W-1:0]   cur_index;
    logic               pte_present;
    logic               pte_writable;
    logic [FRAME_W-1:0] pte_frame;

    always_comb begin
        if (walk_q.state == WALK_DIR) begin
            cur_index = IDX_W'(walk_q.vpn[VPN_W-1 -: LVL1_W]);
        end else begin
            cur_index = IDX_W'(walk_q.vpn[LVL2_W-1:0]);
        end
    end

    ptw_addr_gen #(
        .PA_W        (PA_W),
        .IDX_W       (IDX_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_addr (
        .table_base (walk_q.base),
        .index      (cur_index),
        .entry_addr (mem_req_addr)
    );

    ptw_pte_decode #(
        .ENTRY_W    (ENTRY_W),
        .PAGE_OFF_W (PAGE_OFF_W),
        .FRAME_W    (FRAME_W)
    ) u_decode (
        .entry    (mem_rsp_data),
        .present  (pte_present),
        .writable (pte_writable),
        .frame    (pte_frame)
    );

    always_comb begin
        walk_d        = walk_q;
        mem_req_valid = 1'b0;
        unique case (walk_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    walk_d.state  = WALK_DIR;
                    walk_d.issued = 1'b0;
                    walk_d.vpn    = req_vpn;
                    walk_d.write  = req_write;
                    walk_d.base   = root_base;
                    walk_d.dir_wr = 1'b0;
                    walk_d.code   = FLT_NONE;
                    walk_d.frame  = '0;
                    walk_d.wr_ok  = 1'b0;
                end
            end
            WALK_DIR: begin
                if (!walk_q.issued) begin
                    mem_req_valid = 1'b1;
                    walk_d.issued = 1'b1;
                end else if (mem_rsp_valid) begin
                    walk_d.issued = 1'b0;
                    if (!pte_present) begin
                        walk_d.state = WALK_ERR;
                        walk_d.code  = FLT_DIR;
                    end else begin
                        walk_d.state  = WALK_LEAF;
                        walk_d.base   = {pte_frame, PAGE_OFF_W'(0)};
                        walk_d.dir_wr = pte_writable;
                    end
                end
            end
            WALK_LEAF: begin
                if (!walk_q.issued) begin
                    mem_req_valid = 1'b1;
                    walk_d.issued = 1'b1;
                end else if (mem_rsp_valid) begin
                    walk_d.issued = 1'b0;
                    if (!pte_present) begin
                        walk_d.state = WALK_ERR;
                        walk_d.code  = FLT_LEAF;
                    end else if (walk_q.write && !(walk_q.dir_wr && pte_writable)) begin
                        walk_d.state = WALK_ERR;
                        walk_d.code  = FLT_PROT;
                    end else begin
                        walk_d.state = WALK_OK;
                        walk_d.frame = pte_frame;
                        walk_d.wr_ok = walk_q.dir_wr && pte_writable;
                    end
                end
            end
            WALK_OK, WALK_ERR: begin
                walk_d.state = WALK_IDLE;
            end
            default: begin
                walk_d.state = WALK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        req_ready     = (walk_q.state == WALK_IDLE);
        done_valid    = (walk_q.state == WALK_OK) || (walk_q.state == WALK_ERR);
        done_fault    = (walk_q.state == WALK_ERR);
        fault_code    = walk_q.code;
        done_frame    = walk_q.frame;
        done_writable = walk_q.wr_ok;
    end

    // R9: a read request lasts one cycle and is never repeated back to back
    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R10: no new request is taken while a walk is running
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R5: the completion strobe is a single cycle and the walker returns to idle
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    // R6: an absent directory entry ends the walk with the directory fault code
    assert_dir_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.state == WALK_DIR && walk_q.issued && mem_rsp_valid && !mem_rsp_data[0])
        |=> (done_valid && done_fault && fault_code == FLT_DIR));

    // R8: a write through a read-only path ends in a protection fault
    assert_prot_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.state == WALK_LEAF && walk_q.issued && mem_rsp_valid && mem_rsp_data[0]
         && walk_q.write && !(walk_q.dir_wr && mem_rsp_data[1]))
        |=> (done_fault && fault_code == FLT_PROT));

    // R5: a successful completion never carries a fault code
    assert_ok_no_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |-> (fault_code == FLT_NONE));

endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [19:0] req_vpn;
    logic        req_write;
    logic [31:0] root_base;
    logic        req_ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done_valid;
    logic        done_fault;
    logic [1:0]  fault_code;
    logic [19:0] done_frame;
    logic        done_writable;

    int errors = 0;
    int checks = 0;
    int lat = 1;
    int reads = 0;
    int wait_cnt = 0;
    logic [31:0] pend_addr;
    logic [31:0] addr_log [0:3];
    logic [31:0] tb_mem [logic [31:0]];

    always #2 clk = ~clk;

    pt_walker dut (
        .clk, .rst_n, .req_valid, .req_vpn, .req_write, .root_base, .req_ready,
        .mem_req_valid, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
        .done_valid, .done_fault, .fault_code, .done_frame, .done_writable
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        if (tb_mem.exists(a)) return tb_mem[a];
        return 32'h0;
    endfunction

    // memory responder: answers each request after lat cycles
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'h0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = lookup(pend_addr);
                end
            end
            if (mem_req_valid) begin
                pend_addr = mem_req_addr;
                if (reads < 4) addr_log[reads] = mem_req_addr;
                reads++;
                wait_cnt = lat;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dir_addr(input logic [31:0] root, input logic [19:0] vpn);
        return root + {20'h0, vpn[19:10], 2'b00};
    endfunction

    function automatic logic [31:0] leaf_addr(input logic [31:0] dir_entry, input logic [19:0] vpn);
        return {dir_entry[31:12], 12'h000} + {20'h0, vpn[9:0], 2'b00};
    endfunction

    // runs one walk and checks every visible result
    task automatic walk(input string tag, input logic [31:0] root, input logic [19:0] vpn,
                        input logic wr, input bit poke, input logic [1:0] exp_code,
                        input logic [19:0] exp_frame, input logic exp_w, input int exp_reads,
                        input logic [31:0] exp_a0, input logic [31:0] exp_a1);
        int guard;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        reads     = 0;
        req_valid = 1'b1;
        req_vpn   = vpn;
        req_write = wr;
        root_base = root;
        @(negedge clk);
        req_valid = 1'b0;
        req_vpn   = ~vpn;
        req_write = ~wr;
        root_base = ~root;
        if (poke) begin
            repeat (2) begin
                chk(req_ready == 1'b0, "R10", "ready during walk", 32'(req_ready), 32'h0);
                req_valid = 1'b1;
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        guard = 0;
        while (!done_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(done_valid == 1'b1, tag, "done seen", 32'(done_valid), 32'h1);
        chk(done_fault == (exp_code != 2'b00), tag, "fault flag", 32'(done_fault), 32'(exp_code != 2'b00));
        chk(fault_code == exp_code, tag, "fault code", 32'(fault_code), 32'(exp_code));
        chk(reads == exp_reads, tag, "read count", 32'(reads), 32'(exp_reads));
        if (exp_reads > 0) chk(addr_log[0] == exp_a0, tag, "first read addr", addr_log[0], exp_a0);
        if (exp_reads > 1) chk(addr_log[1] == exp_a1, tag, "second read addr", addr_log[1], exp_a1);
        if (exp_code == 2'b00) begin
            chk(done_frame == exp_frame, tag, "frame", 32'(done_frame), 32'(exp_frame));
            chk(done_writable == exp_w, tag, "writable", 32'(done_writable), 32'(exp_w));
        end
        @(negedge clk);
        chk(done_valid == 1'b0, "R5", "done one cycle", 32'(done_valid), 32'h0);
        chk(req_ready == 1'b1, "R5", "idle after done", 32'(req_ready), 32'h1);
        chk(reads == exp_reads, "R9", "no extra reads", 32'(reads), 32'(exp_reads));
    endtask

    // R2 R3 R4 R5: plain read through present, writable entries
    task automatic t_read_ok();
        logic [31:0] root = 32'h0010_0000;
        logic [19:0] vpn  = 20'h12345;
        logic [31:0] de   = 32'h0020_0003;
        tb_mem.delete();
        lat = 1;
        tb_mem[dir_addr(root, vpn)]  = de;
        tb_mem[leaf_addr(de, vpn)]   = 32'hABCD_E003;
        walk("R3", root, vpn, 1'b0, 1'b0, 2'b00, 20'hABCDE, 1'b1, 2,
             32'h0010_0120, 32'h0020_0D14);
    endtask

    // R9 R5: write allowed, slow memory, ignored bits set in entries (R4)
    task automatic t_write_ok_slow();
        logic [31:0] root = 32'h0004_0000;
        logic [19:0] vpn  = 20'h0F0F0;
        logic [31:0] de   = 32'h0055_5FF3;
        tb_mem.delete();
        lat = 3;
        tb_mem[dir_addr(root, vpn)] = de;
        tb_mem[leaf_addr(de, vpn)]  = 32'h1234_5FFF;
        walk("R4", root, vpn, 1'b1, 1'b0, 2'b00, 20'h12345, 1'b1, 2,
             dir_addr(root, vpn), leaf_addr(de, vpn));
    endtask

    // R8: read-only leaf, read succeeds, write faults
    task automatic t_leaf_readonly();
        logic [31:0] root = 32'h0008_0000;
        logic [19:0] vpn  = 20'h3A5C7;
        logic [31:0] de   = 32'h0009_1003;
        tb_mem.delete();
        lat = 2;
        tb_mem[dir_addr(root, vpn)] = de;
        tb_mem[leaf_addr(de, vpn)]  = 32'h0777_7001;
        walk("R8", root, vpn, 1'b0, 1'b0, 2'b00, 20'h07777, 1'b0, 2,
             dir_addr(root, vpn), leaf_addr(de, vpn));
        walk("R8", root, vpn, 1'b1, 1'b0, 2'b11, 20'h0, 1'b0, 2,
             dir_addr(root, vpn), leaf_addr(de, vpn));
    endtask

    // R8: read-only directory denies writes even to a writable leaf
    task automatic t_dir_readonly();
        logic [31:0] root = 32'h000C_0000;
        logic [19:0] vpn  = 20'h80001;
        logic [31:0] de   = 32'h000D_0001;
        tb_mem.delete();
        lat = 1;
        tb_mem[dir_addr(root, vpn)] = de;
        tb_mem[leaf_addr(de, vpn)]  = 32'h0222_2003;
        walk("R8", root, vpn, 1'b1, 1'b0, 2'b11, 20'h0, 1'b0, 2,
             dir_addr(root, vpn), leaf_addr(de, vpn));
        walk("R8", root, vpn, 1'b0, 1'b0, 2'b00, 20'h02222, 1'b0, 2,
             dir_addr(root, vpn), leaf_addr(de, vpn));
    endtask

    // R6: absent directory entry stops after one read
    task automatic t_dir_absent();
        logic [31:0] root = 32'h0030_0000;
        logic [19:0] vpn  = 20'h55555;
        tb_mem.delete();
        lat = 2;
        tb_mem[dir_addr(root, vpn)] = 32'h0040_0002;
        walk("R6", root, vpn, 1'b0, 1'b0, 2'b01, 20'h0, 1'b0, 1,
             dir_addr(root, vpn), 32'h0);
    endtask

    // R7: absent leaf entry stops after two reads
    task automatic t_leaf_absent();
        logic [31:0] root = 32'h0030_0000;
        logic [19:0] vpn  = 20'h2AAAA;
        logic [31:0] de   = 32'h0041_0003;
        tb_mem.delete();
        lat = 1;
        tb_mem[dir_addr(root, vpn)] = de;
        tb_mem[leaf_addr(de, vpn)]  = 32'hFFFF_F002;
        walk("R7", root, vpn, 1'b0, 1'b0, 2'b10, 20'h0, 1'b0, 2,
             dir_addr(root, vpn), leaf_addr(de, vpn));
    endtask

    // R2: extreme indices 0 and 1023 at both levels
    task automatic t_index_edges();
        logic [31:0] root = 32'h0050_0000;
        tb_mem.delete();
        lat = 1;
        tb_mem[32'h0050_0000] = 32'h0060_0003;
        tb_mem[32'h0060_0000] = 32'h0000_1003;
        tb_mem[32'h0050_0FFC] = 32'h0070_0003;
        tb_mem[32'h0070_0FFC] = 32'hFFFF_F003;
        walk("R2", root, 20'h00000, 1'b0, 1'b0, 2'b00, 20'h00001, 1'b1, 2,
             32'h0050_0000, 32'h0060_0000);
        walk("R2", root, 20'hFFFFF, 1'b0, 1'b0, 2'b00, 20'hFFFFF, 1'b1, 2,
             32'h0050_0FFC, 32'h0070_0FFC);
    endtask

    // R10: extra request pulses during a walk are ignored
    task automatic t_busy_ignore();
        logic [31:0] root = 32'h0010_0000;
        logic [19:0] vpn  = 20'h00401;
        logic [31:0] de   = 32'h0021_0003;
        tb_mem.delete();
        lat = 3;
        tb_mem[dir_addr(root, vpn)] = de;
        tb_mem[leaf_addr(de, vpn)]  = 32'h0BEE_F003;
        walk("R10", root, vpn, 1'b0, 1'b1, 2'b00, 20'h0BEEF, 1'b1, 2,
             32'h0010_0004, 32'h0021_0004);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vpn   = '0;
        req_write = 1'b0;
        root_base = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
        chk(done_valid == 1'b0, "R1", "done after reset", 32'(done_valid), 32'h0);
        chk(mem_req_valid == 1'b0, "R1", "mem req after reset", 32'(mem_req_valid), 32'h0);
        t_read_ok();
        t_write_ok_slow();
        t_leaf_readonly();
        t_dir_readonly();
        t_dir_absent();
        t_leaf_absent();
        t_index_edges();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule